// File: doc/BRIEF.md
# Word-State First-Level Cache With Phase-End Self-Invalidation

This block is the private first-level cache controller of one core in a system whose parallel code runs in phases with declared write effects. The cache is direct-mapped and line-based. Each line carries one address tag, and each word of the line carries its own coherence state: Invalid, Valid or Registered. These are the only states. No transient state exists, and no invalidation or acknowledgement ever arrives from outside. A store takes ownership of its word with a fire-and-forget registration message to the shared level. A load to a word that holds no valid copy fetches that word alone. Because state is held per word, two cores can own different words of one line without false sharing.

Every word also records a 3-bit region identifier and a touched flag. When a phase ends, software raises `phase_end` with a bitmask of the regions that any core wrote during that phase. The controller then walks the array one line per cycle. It drops every word whose region is in the mask and which this core did not access during the phase, and it clears all touched flags. Core requests stall while the walk runs, and a one-cycle pulse marks the end of the walk.

Top module: `wstate_l1`

## Requirements
- R1: After reset every word is Invalid, `req_ready` is high, and `resp_valid`, `l2_req_valid`, `conflict_err` and `sweep_done` are low.
- R2: An accepted store writes the word, makes it Registered, and records the request's region. In the next cycle it sends one registration message: `l2_req_valid`=1, `l2_req_kind`=1, with the store's word address and data. A store produces no `resp_valid`.
- R3: An accepted load whose tag matches and whose word is Valid or Registered returns that word's data with `resp_valid` in the next cycle. It sends no shared-level message, and it leaves the word's region unchanged.
- R4: An accepted load to an Invalid word sends a fetch message in the next cycle (`l2_req_kind`=0, the word address). The cycle after `l2_fill_valid` is sampled, it returns `l2_fill_data` on `resp_valid`. The word becomes Valid and takes the request's region.
- R5: A store or fill changes the state and data of the addressed word only. The other words of the same line keep their states and data.
- R6: At the end of a sweep, a word is Invalid if bit r of the phase mask is set (r being the word's region) and the word was not accessed since the previous sweep. Every other word keeps its state and data.
- R7: The sweep begins on the edge that samples `phase_end` while the controller is idle. It takes one cycle per line, and `sweep_done` is high for exactly one cycle, directly after the last line is processed (the cycle after NLINES edges).
- R8: `req_ready` is low in the cycle `phase_end` is high and for the whole sweep, and no shared-level message is sent during it.
- R9: A store, or a load to an Invalid word, whose tag differs from the line's tag while the line holds a Registered word is not accepted. `conflict_err` is high and `req_ready` is low, and the cache is unchanged.
- R10: A store, or a load miss, with a different tag on a line that has no Registered word takes the line: the new tag is stored and every other word of the line becomes Invalid.
- R11: A sweep clears all touched flags, so a word that survives one sweep because it was accessed is dropped by the next sweep if it is not accessed again and its region is still in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address {tag, line index, word offset} |
| req_wdata | input | DATA_W | Store data |
| req_region | input | 3 | Region identifier of the accessed word |
| req_ready | output | 1 | Request accepted on this edge |
| resp_valid | output | 1 | Load data valid |
| resp_rdata | output | DATA_W | Load data |
| conflict_err | output | 1 | Request blocked by a registered line of another tag |
| l2_req_valid | output | 1 | Message to the shared level |
| l2_req_kind | output | 1 | 0 = word fetch, 1 = registration |
| l2_req_addr | output | ADDR_W | Word address of the message |
| l2_req_wdata | output | DATA_W | Registered data (zero for a fetch) |
| l2_fill_valid | input | 1 | Fetched word arrives |
| l2_fill_data | input | DATA_W | Fetched word |
| phase_end | input | 1 | Phase finished, start self-invalidation |
| phase_regions | input | 8 | Mask of regions written in the phase |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
Random loads and stores are confined to two tags and a few lines, so that tag hits, word misses inside a valid line, evictions of clean lines and registered-line conflicts all occur often. Each of these cases produces a different pattern of response, fetch and error. Directed sequences first fill one word and store its neighbour in the same line, which separates per-word state from per-line state. Back-to-back sweeps with the same mask then separate the touched flag from the region match: the first sweep keeps the touched words and the second drops them. The random phase masks vary which regions survive, so each sweep is checked against a model of the region and touched bits.

// File: rtl/wstate_l1.sv
module wstate_l1 #(
  parameter int NLINES = 8,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int REG_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [REG_W-1:0]      req_region,
  output logic                  req_ready,
  output logic                  resp_valid,
  output logic [DATA_W-1:0]     resp_rdata,
  output logic                  conflict_err,
  output logic                  l2_req_valid,
  output logic                  l2_req_kind,
  output logic [ADDR_W-1:0]     l2_req_addr,
  output logic [DATA_W-1:0]     l2_req_wdata,
  input  logic                  l2_fill_valid,
  input  logic [DATA_W-1:0]     l2_fill_data,
  input  logic                  phase_end,
  input  logic [(1<<REG_W)-1:0] phase_regions,
  output logic                  sweep_done
);
  localparam int IDX_W = $clog2(NLINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int NREG  = 1 << REG_W;
  localparam logic [1:0] W_INV = 2'd0, W_VAL = 2'd1, W_REG = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SWEEP} fsm_t;
  fsm_t fsm;

  logic [TAG_W-1:0]  tag_q [NLINES];
  logic [1:0]        wst_q [NLINES][WORDS];
  logic [DATA_W-1:0] dat_q [NLINES][WORDS];
  logic [REG_W-1:0]  rgn_q [NLINES][WORDS];
  logic              tch_q [NLINES][WORDS];

  logic [IDX_W-1:0] ptr, pend_idx;
  logic [OFF_W-1:0] pend_off;
  logic [REG_W-1:0] pend_rgn;
  logic [NREG-1:0]  mask_q;

  wire [TAG_W-1:0] a_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] a_idx = req_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] a_off = req_addr[OFF_W-1:0];

  logic line_has_reg;
  always_comb begin
    line_has_reg = 1'b0;
    for (int w = 0; w < WORDS; w++)
      if (wst_q[a_idx][w] == W_REG) line_has_reg = 1'b1;
  end

  wire idle     = (fsm == S_IDLE);
  wire tag_hit  = (tag_q[a_idx] == a_tag);
  wire ld_hit   = !req_write && tag_hit && (wst_q[a_idx][a_off] != W_INV);
  wire conflict = !tag_hit && line_has_reg;
  wire accept   = req_valid && req_ready;

  assign req_ready    = idle && !phase_end && !conflict;
  assign conflict_err = idle && !phase_end && req_valid && conflict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm          <= S_IDLE;
      ptr          <= '0;
      pend_idx     <= '0;
      pend_off     <= '0;
      pend_rgn     <= '0;
      mask_q       <= '0;
      resp_valid   <= 1'b0;
      resp_rdata   <= '0;
      l2_req_valid <= 1'b0;
      l2_req_kind  <= 1'b0;
      l2_req_addr  <= '0;
      l2_req_wdata <= '0;
      sweep_done   <= 1'b0;
      for (int l = 0; l < NLINES; l++) begin
        tag_q[l] <= '0;
        for (int w = 0; w < WORDS; w++) begin
          wst_q[l][w] <= W_INV;
          dat_q[l][w] <= '0;
          rgn_q[l][w] <= '0;
          tch_q[l][w] <= 1'b0;
        end
      end
    end else begin
      resp_valid   <= 1'b0;
      l2_req_valid <= 1'b0;
      sweep_done   <= 1'b0;
      case (fsm)
        S_IDLE: begin
          if (phase_end) begin
            mask_q <= phase_regions;
            ptr    <= '0;
            fsm    <= S_SWEEP;
          end else if (accept) begin
            if (!tag_hit) begin
              tag_q[a_idx] <= a_tag;
              for (int w = 0; w < WORDS; w++) begin
                wst_q[a_idx][w] <= W_INV;
                tch_q[a_idx][w] <= 1'b0;
              end
            end
            if (req_write) begin
              dat_q[a_idx][a_off] <= req_wdata;
              wst_q[a_idx][a_off] <= W_REG;
              rgn_q[a_idx][a_off] <= req_region;
              tch_q[a_idx][a_off] <= 1'b1;
              l2_req_valid        <= 1'b1;
              l2_req_kind         <= 1'b1;
              l2_req_addr         <= req_addr;
              l2_req_wdata        <= req_wdata;
            end else if (ld_hit) begin
              resp_valid          <= 1'b1;
              resp_rdata          <= dat_q[a_idx][a_off];
              tch_q[a_idx][a_off] <= 1'b1;
            end else begin
              l2_req_valid <= 1'b1;
              l2_req_kind  <= 1'b0;
              l2_req_addr  <= req_addr;
              l2_req_wdata <= '0;
              pend_idx     <= a_idx;
              pend_off     <= a_off;
              pend_rgn     <= req_region;
              fsm          <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (l2_fill_valid) begin
            dat_q[pend_idx][pend_off] <= l2_fill_data;
            wst_q[pend_idx][pend_off] <= W_VAL;
            rgn_q[pend_idx][pend_off] <= pend_rgn;
            tch_q[pend_idx][pend_off] <= 1'b1;
            resp_valid                <= 1'b1;
            resp_rdata                <= l2_fill_data;
            fsm                       <= S_IDLE;
          end
        end
        S_SWEEP: begin
          for (int w = 0; w < WORDS; w++) begin
            if (mask_q[rgn_q[ptr][w]] && !tch_q[ptr][w]) wst_q[ptr][w] <= W_INV;
            tch_q[ptr][w] <= 1'b0;
          end
          ptr <= ptr + 1'b1;
          if (ptr == IDX_W'(NLINES - 1)) begin
            fsm        <= S_IDLE;
            sweep_done <= 1'b1;
          end
        end
        default: fsm <= S_IDLE;
      endcase
    end
  end
endmodule

module wstate_l1_chk #(
  parameter int NLINES = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idle,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              resp_valid,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              conflict_err,
  input logic              l2_req_valid,
  input logic              l2_req_kind,
  input logic [ADDR_W-1:0] l2_req_addr,
  input logic [DATA_W-1:0] l2_req_wdata,
  input logic              l2_fill_valid,
  input logic [DATA_W-1:0] l2_fill_data,
  input logic              phase_end,
  input logic              sweep_done
);
  localparam int CW = $clog2(NLINES) + 2;
  logic [CW-1:0] sw_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) sw_cnt <= '0;
    else if (sweep_done) sw_cnt <= '0;
    else if (idle && phase_end && sw_cnt == '0) sw_cnt <= CW'(1);
    else if (sw_cnt != '0) sw_cnt <= sw_cnt + 1'b1;
  end

  assert_registration_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=>
      (l2_req_valid && l2_req_kind && l2_req_addr == $past(req_addr) &&
       l2_req_wdata == $past(req_wdata) && !resp_valid));

  assert_hit_or_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=>
      (resp_valid != (l2_req_valid && !l2_req_kind)));

  assert_fill_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && sw_cnt == '0 && l2_fill_valid) |=>
      (resp_valid && resp_rdata == $past(l2_fill_data)));

  assert_done_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |-> (sw_cnt == CW'(NLINES + 1)));

  assert_sweep_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cnt != '0 && !sweep_done) |-> (!req_ready && !l2_req_valid));

  assert_conflict_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_err |-> !req_ready);
endmodule

bind wstate_l1 wstate_l1_chk #(.NLINES(NLINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .req_addr(req_addr), .req_wdata(req_wdata),
  .resp_valid(resp_valid), .resp_rdata(resp_rdata), .conflict_err(conflict_err),
  .l2_req_valid(l2_req_valid), .l2_req_kind(l2_req_kind), .l2_req_addr(l2_req_addr),
  .l2_req_wdata(l2_req_wdata), .l2_fill_valid(l2_fill_valid), .l2_fill_data(l2_fill_data),
  .phase_end(phase_end), .sweep_done(sweep_done)
);

// File: tb/wstate_l1_tb.sv
module wstate_l1_tb;
  localparam int NL = 8, NW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  req_region = '0;
  logic req_ready, resp_valid, conflict_err, l2_req_valid, l2_req_kind, sweep_done;
  logic [31:0] resp_rdata, l2_req_wdata;
  logic [11:0] l2_req_addr;
  logic l2_fill_valid = 0;
  logic [31:0] l2_fill_data = '0;
  logic phase_end = 0;
  logic [7:0] phase_regions = '0;

  always #4 clk = ~clk;

  wstate_l1 u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_region(req_region),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .conflict_err(conflict_err), .l2_req_valid(l2_req_valid), .l2_req_kind(l2_req_kind),
    .l2_req_addr(l2_req_addr), .l2_req_wdata(l2_req_wdata), .l2_fill_valid(l2_fill_valid),
    .l2_fill_data(l2_fill_data), .phase_end(phase_end), .phase_regions(phase_regions),
    .sweep_done(sweep_done)
  );

  int n_chk = 0, n_bad = 0;
  int m_tag [NL];
  int m_st  [NL][NW];
  logic [31:0] m_dat [NL][NW];
  int m_rgn [NL][NW];
  bit m_tch [NL][NW];

  function automatic logic [31:0] fillv(input logic [11:0] a);
    return 32'hA500_0000 ^ ({20'd0, a} * 32'h0001_0003);
  endfunction

  task automatic chk(input bit ok, input string tg, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [2:0] rg, input string tg);
    int idx, off, t;
    bit tmatch, hasr, hit;
    idx = int'(a[4:2]); off = int'(a[1:0]); t = int'(a[11:5]);
    tmatch = (m_tag[idx] == t);
    hasr = 0;
    for (int w = 0; w < NW; w++) if (m_st[idx][w] == 2) hasr = 1;
    hit = !wr && tmatch && m_st[idx][off] != 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_region = rg;
    #1;
    if (!tmatch && hasr && !hit) begin
      chk(conflict_err === 1'b1 && req_ready === 1'b0, tg, "conflict flag/ready",
          {30'd0, conflict_err, req_ready}, 32'd2);
      req_valid = 0;
      return;
    end
    chk(req_ready === 1'b1 && conflict_err === 1'b0, tg, "accept",
        {30'd0, conflict_err, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 0;
    if (!tmatch) begin
      m_tag[idx] = t;
      for (int w = 0; w < NW; w++) begin m_st[idx][w] = 0; m_tch[idx][w] = 0; end
    end
    if (wr) begin
      chk(l2_req_valid === 1'b1 && l2_req_kind === 1'b1 && l2_req_addr === a &&
          l2_req_wdata === d && resp_valid === 1'b0, tg, "registration msg",
          l2_req_wdata, d);
      m_st[idx][off] = 2; m_dat[idx][off] = d; m_rgn[idx][off] = int'(rg);
      m_tch[idx][off] = 1;
    end else if (hit) begin
      chk(resp_valid === 1'b1 && resp_rdata === m_dat[idx][off] && l2_req_valid === 1'b0,
          tg, "load hit data", resp_rdata, m_dat[idx][off]);
      m_tch[idx][off] = 1;
    end else begin
      chk(l2_req_valid === 1'b1 && l2_req_kind === 1'b0 && l2_req_addr === a &&
          resp_valid === 1'b0, tg, "fetch msg", {20'd0, l2_req_addr}, {20'd0, a});
      l2_fill_valid = 1; l2_fill_data = fillv(a);
      @(negedge clk);
      l2_fill_valid = 0;
      chk(resp_valid === 1'b1 && resp_rdata === fillv(a), tg, "fill data",
          resp_rdata, fillv(a));
      m_st[idx][off] = 1; m_dat[idx][off] = fillv(a); m_rgn[idx][off] = int'(rg);
      m_tch[idx][off] = 1;
    end
  endtask

  task automatic phase(input logic [7:0] mask);
    @(negedge clk);
    phase_end = 1; phase_regions = mask;
    req_valid = 1; req_write = 1; req_addr = 12'h000; req_wdata = 32'hDEAD; req_region = 0;
    #1;
    chk(req_ready === 1'b0, "R8", "ready on phase_end", {31'd0, req_ready}, 0);
    @(negedge clk);
    phase_end = 0;
    for (int c = 0; c < NL; c++) begin
      chk(req_ready === 1'b0 && sweep_done === 1'b0 && l2_req_valid === 1'b0, "R8",
          "stall during sweep", {29'd0, req_ready, sweep_done, l2_req_valid}, 0);
      if (c == NL - 1) req_valid = 0;
      @(negedge clk);
    end
    chk(sweep_done === 1'b1, "R7", "done pulse", {31'd0, sweep_done}, 1);
    @(negedge clk);
    chk(sweep_done === 1'b0, "R7", "done width", {31'd0, sweep_done}, 0);
    for (int l = 0; l < NL; l++)
      for (int w = 0; w < NW; w++) begin
        if (mask[m_rgn[l][w]] && !m_tch[l][w]) m_st[l][w] = 0;
        m_tch[l][w] = 0;
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int l = 0; l < NL; l++) begin
      m_tag[l] = 0;
      for (int w = 0; w < NW; w++) begin
        m_st[l][w] = 0; m_dat[l][w] = '0; m_rgn[l][w] = 0; m_tch[l][w] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk(req_ready === 1'b1 && resp_valid === 1'b0 && l2_req_valid === 1'b0 &&
        conflict_err === 1'b0 && sweep_done === 1'b0, "R1", "reset outputs",
        {27'd0, req_ready, resp_valid, l2_req_valid, conflict_err, sweep_done}, 32'h10);

    do_req(0, 12'h000, 0, 3'd5, "R1 R4");   // invalid after reset: fetch
    do_req(0, 12'h000, 0, 3'd5, "R3");      // valid hit
    do_req(1, 12'h001, 32'h1111_2222, 3'd2, "R2");
    do_req(0, 12'h001, 0, 3'd0, "R2 R3");   // registered hit
    do_req(0, 12'h002, 0, 3'd2, "R4 R5");   // neighbour word fetched alone
    do_req(0, 12'h000, 0, 3'd0, "R5");      // word 0 unchanged
    do_req(0, 12'h001, 0, 3'd0, "R5");      // word 1 still registered
    do_req(1, 12'h020, 32'h3, 3'd1, "R9");  // other tag, registered line
    do_req(0, 12'h001, 0, 3'd0, "R9");      // cache unchanged
    do_req(0, 12'h004, 0, 3'd2, "R4");
    do_req(1, 12'h025, 32'h55, 3'd3, "R10"); // clean line taken
    do_req(0, 12'h024, 0, 3'd3, "R10");      // old words gone: miss
    phase(8'b0000_0100);                     // region 2 written, all touched
    do_req(0, 12'h002, 0, 3'd2, "R6");       // touched: survived
    phase(8'b0000_0100);                     // 0x001 untouched now
    do_req(0, 12'h001, 0, 3'd2, "R11");      // dropped: fetch
    do_req(0, 12'h000, 0, 3'd5, "R6");       // region 5 not in mask: hit
    do_req(0, 12'h002, 0, 3'd2, "R11");

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      a = {6'd0, 1'($urandom % 2), 3'($urandom % 4), 2'($urandom % 4)};
      if (i % 30 == 29) phase(8'($urandom));
      else do_req(1'($urandom % 3 == 0), a, $urandom, 3'($urandom), "R2/R3/R4/R9/R10");
    end
    phase(8'hFF);
    for (int w = 0; w < NW; w++) do_req(0, {7'd0, 3'd0, 2'(w)}, 0, 3'd1, "R6/R9/R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule